// File: doc/BRIEF.md
# Wide-Beat Array Increment Engine

This engine moves a fixed block of 64 signed 32-bit integers from one buffer in memory to another and adds a constant of 100 to every element on the way. Software sets a source address and a destination address through a small register port and then sets a start bit. The engine issues one read burst and one write burst over a 256-bit memory bus. Each beat carries eight elements, which are incremented side by side. Completion shows up as a done flag that clears on read, and as an idle flag.

The memory side has five valid/ready channels: read address, read data, write address, write data and write response. Back-pressure rules are as follows. A payload offered with valid is held stable until ready is seen. The engine raises read-data ready only while it is busy and its single pipeline stage is empty or draining into an accepted write beat. It therefore holds read data off whenever write ready is low and the stage is full, and no element is dropped or duplicated. The write-address and write-data channels are independent. The write response ends the command.

Top module: `vinc_engine`

## Requirements
- R1: After reset all memory-side valid outputs are low, the idle output is 1, the done output is 0, and the control register (offset 0x00) reads 0x4: bit 2 is idle = 1, bit 1 is done = 0, bit 0 is start = 0.
- R2: Writing a 1 to bit 0 of the control register at offset 0x00 starts the engine when it is idle. The start bit reads back as 0 once the engine has accepted the command.
- R3: Each command issues exactly one read burst at the source address and one write burst at the destination address. The length field of each burst is 7, which means 8 beats. Each address stays stable while its valid waits for ready.
- R4: Each output element equals its input element plus 100. Lane k of a 256-bit beat occupies bits 32k+31:32k, so lane 0 sits in bits 31:0. Beat n covers elements 8n to 8n+7.
- R5: The addition wraps modulo 2^32. For example, 0x7FFFFFFF becomes 0x80000063 and 0xFFFFFFFF becomes 0x00000063.
- R6: The source address register is at offset 0x10 and the destination address register is at offset 0x1C. Address bits 5:0 are not stored: they read as 0 and are driven as 0 on the bus, so both buffers are 64-byte aligned.
- R7: When read-data valid or write-data ready drops, the engine stalls without losing data. A write beat offered while write ready is low stays valid with unchanged data. Every accepted read beat appears as a write beat.
- R8: With both memory channels always ready, the eight write beats complete in eight consecutive cycles, one beat per cycle.
- R9: The done bit (control bit 1) sets when the write response is accepted. It reads as 1 once and then as 0, because a read of the control register clears it. Idle (bit 2) reads as 0 while a command runs and as 1 afterwards.
- R10: Write-data last is asserted on the eighth beat of the burst and on no other beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr | input | 1 | Register write strobe |
| csr_rd | input | 1 | Register read strobe; data appears on the next cycle |
| csr_addr | input | 8 | Register byte offset |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data, registered |
| mem_ar_valid | output | 1 | Read address valid |
| mem_ar_ready | input | 1 | Read address ready |
| mem_ar_addr | output | 32 | Read burst byte address |
| mem_ar_len | output | 8 | Read burst length minus one |
| mem_r_valid | input | 1 | Read data valid |
| mem_r_ready | output | 1 | Read data ready |
| mem_r_data | input | 256 | Read data beat, eight lanes |
| mem_aw_valid | output | 1 | Write address valid |
| mem_aw_ready | input | 1 | Write address ready |
| mem_aw_addr | output | 32 | Write burst byte address |
| mem_aw_len | output | 8 | Write burst length minus one |
| mem_w_valid | output | 1 | Write data valid |
| mem_w_ready | input | 1 | Write data ready |
| mem_w_data | output | 256 | Write data beat, eight lanes |
| mem_w_last | output | 1 | Final beat of the write burst |
| mem_b_valid | input | 1 | Write response valid |
| mem_b_ready | output | 1 | Write response ready |
| eng_idle | output | 1 | Engine has no command in progress |
| eng_done | output | 1 | Sticky completion flag, cleared by a control-register read |

## Verification
The bench builds the engine with its default parameters: 64 elements, 32-bit lanes on a 256-bit bus (eight lanes and eight beats) and an increment of 100. These values put a full 8-beat burst within reach, along with the boundary between element 7 and element 8 across beats. They also let the test data straddle both signed and unsigned 32-bit wrap points. The behavioural memory can insert gaps in read data and drops in write ready on independent patterns. This exercises the single-stage stall path with both causes alone and together, and it also allows an unstalled run for the one-beat-per-cycle rate.

// File: rtl/vinc_pkg.sv
package vinc_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } vinc_state_e;

  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_SRC  = 8'h10;
  localparam logic [7:0] OFS_DST  = 8'h1C;

  localparam int CTRL_START_BIT = 0;
  localparam int CTRL_DONE_BIT  = 1;
  localparam int CTRL_IDLE_BIT  = 2;
endpackage

// File: rtl/vinc_regs.sv
module vinc_regs
  import vinc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int ALIGN_LSB = 6,
  parameter int DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [7:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr,
  output logic              start_req,
  input  logic              start_ack,
  input  logic              done_set,
  input  logic              busy,
  output logic              done_flag
);
  localparam int HI_W = ADDR_W - ALIGN_LSB;

  logic [HI_W-1:0] src_hi;
  logic [HI_W-1:0] dst_hi;
  logic            start_pend;
  logic            ctrl_wr, ctrl_rd;
  logic            unused_wbits;

  assign ctrl_wr = wr && (addr == OFS_CTRL);
  assign ctrl_rd = rd && (addr == OFS_CTRL);
  assign unused_wbits = ^wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_hi     <= '0;
      dst_hi     <= '0;
      start_pend <= 1'b0;
      done_flag  <= 1'b0;
      rdata      <= '0;
    end else begin
      if (wr && addr == OFS_SRC) src_hi <= wdata[ADDR_W-1:ALIGN_LSB];
      if (wr && addr == OFS_DST) dst_hi <= wdata[ADDR_W-1:ALIGN_LSB];

      if (ctrl_wr && wdata[CTRL_START_BIT]) start_pend <= 1'b1;
      else if (start_ack)                   start_pend <= 1'b0;

      if (done_set)     done_flag <= 1'b1;
      else if (ctrl_rd) done_flag <= 1'b0;

      if (rd) begin
        case (addr)
          OFS_CTRL: begin
            rdata                 <= '0;
            rdata[CTRL_START_BIT] <= start_pend;
            rdata[CTRL_DONE_BIT]  <= done_flag;
            rdata[CTRL_IDLE_BIT]  <= !busy;
          end
          OFS_SRC: rdata <= DATA_W'({src_hi, {ALIGN_LSB{1'b0}}});
          OFS_DST: rdata <= DATA_W'({dst_hi, {ALIGN_LSB{1'b0}}});
          default: rdata <= '0;
        endcase
      end
    end
  end

  assign src_addr  = {src_hi, {ALIGN_LSB{1'b0}}};
  assign dst_addr  = {dst_hi, {ALIGN_LSB{1'b0}}};
  assign start_req = start_pend;

  AST_START_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    start_ack && !ctrl_wr |=> !start_pend) else $error("start not cleared"); // R2
  AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    done_set |=> done_flag) else $error("done not set"); // R9
endmodule

// File: rtl/vinc_ctrl.sv
module vinc_ctrl
  import vinc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int ALIGN_LSB = 6,
  parameter int BEATS     = 8,
  parameter int LEN_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [ADDR_W-1:0] dst_addr,
  output logic              start_ack,
  output logic              done_set,
  output logic              busy,
  output logic              ar_valid,
  input  logic              ar_ready,
  output logic [ADDR_W-1:0] ar_addr,
  output logic [LEN_W-1:0]  ar_len,
  output logic              aw_valid,
  input  logic              aw_ready,
  output logic [ADDR_W-1:0] aw_addr,
  output logic [LEN_W-1:0]  aw_len,
  input  logic              w_fire,
  output logic              w_last,
  input  logic              b_valid,
  output logic              b_ready
);
  localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BEATS - 1);

  vinc_state_e      st;
  logic [CNT_W-1:0] wcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      ar_valid <= 1'b0;
      aw_valid <= 1'b0;
      ar_addr  <= '0;
      aw_addr  <= '0;
      wcnt     <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (start_req) begin
            st       <= ST_RUN;
            ar_valid <= 1'b1;
            aw_valid <= 1'b1;
            ar_addr  <= src_addr;
            aw_addr  <= dst_addr;
            wcnt     <= '0;
          end
        end
        ST_RUN: begin
          if (ar_valid && ar_ready) ar_valid <= 1'b0;
          if (aw_valid && aw_ready) aw_valid <= 1'b0;
          if (w_fire) wcnt <= w_last ? '0 : wcnt + 1'b1;
          if (b_valid) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (st == ST_RUN);
  assign start_ack = (st == ST_IDLE) && start_req;
  assign done_set  = (st == ST_RUN) && b_valid;
  assign b_ready   = busy;
  assign w_last    = (wcnt == LAST_IDX);
  assign ar_len    = LEN_W'(BEATS - 1);
  assign aw_len    = LEN_W'(BEATS - 1);

  AST_AR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ar_valid && !ar_ready |=> ar_valid && $stable(ar_addr)) else $error("ar dropped"); // R3
  AST_AW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    aw_valid && !aw_ready |=> aw_valid && $stable(aw_addr)) else $error("aw dropped"); // R3
  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    ar_valid |-> ar_addr[ALIGN_LSB-1:0] == '0) else $error("unaligned read"); // R6
  AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_set |=> !busy) else $error("busy after done"); // R9
endmodule

// File: rtl/vinc_lanes.sv
module vinc_lanes #(
  parameter int LANES  = 8,
  parameter int LANE_W = 32,
  parameter int INC    = 100
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enable,
  input  logic                    r_valid,
  output logic                    r_ready,
  input  logic [LANES*LANE_W-1:0] r_data,
  output logic                    w_valid,
  input  logic                    w_ready,
  output logic [LANES*LANE_W-1:0] w_data
);
  localparam int BUS_W = LANES * LANE_W;
  localparam logic [LANE_W-1:0] INC_W = LANE_W'(INC);

  logic [BUS_W-1:0] sum;
  logic [BUS_W-1:0] stg;
  logic             stg_v;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign sum[k*LANE_W +: LANE_W] = r_data[k*LANE_W +: LANE_W] + INC_W;
  end

  assign r_ready = enable && (!stg_v || w_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_v <= 1'b0;
      stg   <= '0;
    end else if (r_valid && r_ready) begin
      stg_v <= 1'b1;
      stg   <= sum;
    end else if (w_ready) begin
      stg_v <= 1'b0;
    end
  end

  assign w_valid = stg_v;
  assign w_data  = stg;

  AST_W_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    w_valid && !w_ready |=> w_valid && $stable(w_data)) else $error("w payload moved"); // R7
  AST_BEAT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    r_valid && r_ready |=> w_valid) else $error("beat lost"); // R7
  AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !r_ready) else $error("read while idle"); // R9
endmodule

// File: rtl/vinc_engine.sv
module vinc_engine
  import vinc_pkg::*;
#(
  parameter int ELEMS     = 64,
  parameter int LANE_W    = 32,
  parameter int BUS_W     = 256,
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 8,
  parameter int ALIGN_LSB = 6,
  parameter int INC       = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_wr,
  input  logic              csr_rd,
  input  logic [7:0]        csr_addr,
  input  logic [31:0]       csr_wdata,
  output logic [31:0]       csr_rdata,
  output logic              mem_ar_valid,
  input  logic              mem_ar_ready,
  output logic [ADDR_W-1:0] mem_ar_addr,
  output logic [LEN_W-1:0]  mem_ar_len,
  input  logic              mem_r_valid,
  output logic              mem_r_ready,
  input  logic [BUS_W-1:0]  mem_r_data,
  output logic              mem_aw_valid,
  input  logic              mem_aw_ready,
  output logic [ADDR_W-1:0] mem_aw_addr,
  output logic [LEN_W-1:0]  mem_aw_len,
  output logic              mem_w_valid,
  input  logic              mem_w_ready,
  output logic [BUS_W-1:0]  mem_w_data,
  output logic              mem_w_last,
  input  logic              mem_b_valid,
  output logic              mem_b_ready,
  output logic              eng_idle,
  output logic              eng_done
);
  localparam int LANES = BUS_W / LANE_W;
  localparam int BEATS = ELEMS / LANES;

  logic [ADDR_W-1:0] src_addr, dst_addr;
  logic start_req, start_ack, done_set, busy;

  vinc_regs #(.ADDR_W(ADDR_W), .ALIGN_LSB(ALIGN_LSB), .DATA_W(32)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(csr_wr), .rd(csr_rd), .addr(csr_addr),
    .wdata(csr_wdata), .rdata(csr_rdata), .src_addr(src_addr), .dst_addr(dst_addr),
    .start_req(start_req), .start_ack(start_ack), .done_set(done_set),
    .busy(busy), .done_flag(eng_done)
  );

  vinc_ctrl #(.ADDR_W(ADDR_W), .ALIGN_LSB(ALIGN_LSB), .BEATS(BEATS), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .src_addr(src_addr),
    .dst_addr(dst_addr), .start_ack(start_ack), .done_set(done_set), .busy(busy),
    .ar_valid(mem_ar_valid), .ar_ready(mem_ar_ready), .ar_addr(mem_ar_addr),
    .ar_len(mem_ar_len), .aw_valid(mem_aw_valid), .aw_ready(mem_aw_ready),
    .aw_addr(mem_aw_addr), .aw_len(mem_aw_len),
    .w_fire(mem_w_valid && mem_w_ready), .w_last(mem_w_last),
    .b_valid(mem_b_valid), .b_ready(mem_b_ready)
  );

  vinc_lanes #(.LANES(LANES), .LANE_W(LANE_W), .INC(INC)) u_lanes (
    .clk(clk), .rst_n(rst_n), .enable(busy),
    .r_valid(mem_r_valid), .r_ready(mem_r_ready), .r_data(mem_r_data),
    .w_valid(mem_w_valid), .w_ready(mem_w_ready), .w_data(mem_w_data)
  );

  assign eng_idle = !busy;

  AST_LAST_ONLY_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    mem_w_valid && mem_w_ready && mem_w_last |=> !(mem_w_valid && mem_w_ready && mem_w_last))
    else $error("double last"); // R10
endmodule

// File: tb/vinc_engine_bench.sv
module vinc_engine_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic         csr_wr = 0, csr_rd = 0;
  logic [7:0]   csr_addr = 0;
  logic [31:0]  csr_wdata = 0, csr_rdata;
  logic         mem_ar_valid, mem_ar_ready, mem_r_valid, mem_r_ready;
  logic [31:0]  mem_ar_addr, mem_aw_addr;
  logic [7:0]   mem_ar_len, mem_aw_len;
  logic [255:0] mem_r_data, mem_w_data;
  logic         mem_aw_valid, mem_aw_ready, mem_w_valid, mem_w_ready, mem_w_last;
  logic         mem_b_valid, mem_b_ready, eng_idle, eng_done;

  vinc_engine u_vinc_engine (.*);

  int total = 0, bad = 0;
  logic [31:0] mem [0:1023];
  logic rstall_en = 0, wstall_en = 0;

  int cyc, ar_cnt, aw_cnt, w_beats, last_cnt, wlast_bad, hold_bad, first_w, last_w, burst_idx;
  logic [31:0] ar_seen_addr, aw_seen_addr;
  logic [7:0]  ar_seen_len, aw_seen_len;
  int rd_left;
  logic [31:0] rd_ptr, wr_ptr;
  logic aw_open, prev_stall;
  logic [255:0] prev_data, rbeat;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      mem_ar_ready <= 1; mem_aw_ready <= 1; mem_r_valid <= 0; mem_w_ready <= 0;
      mem_b_valid <= 0; mem_r_data <= '0;
      ar_cnt <= 0; aw_cnt <= 0; w_beats <= 0; last_cnt <= 0; wlast_bad <= 0;
      hold_bad <= 0; first_w <= 0; last_w <= 0; burst_idx <= 0; prev_stall <= 0;
      rd_left = 0; rd_ptr = 0; wr_ptr = 0; aw_open = 0;
    end else begin
      if (mem_r_valid && mem_r_ready) begin rd_left = rd_left - 1; rd_ptr = rd_ptr + 32; end
      if (mem_ar_valid && mem_ar_ready) begin
        ar_cnt <= ar_cnt + 1; ar_seen_addr <= mem_ar_addr; ar_seen_len <= mem_ar_len;
        rd_ptr = mem_ar_addr; rd_left = int'(mem_ar_len) + 1;
      end
      if (mem_r_valid && !mem_r_ready) begin
        mem_r_valid <= 1;
      end else if (rd_left > 0 && (!rstall_en || (cyc % 4) != 1)) begin
        for (int k = 0; k < 8; k++) rbeat[k*32 +: 32] = mem[((rd_ptr >> 2) + k) & 1023];
        mem_r_data <= rbeat; mem_r_valid <= 1;
      end else mem_r_valid <= 0;

      if (prev_stall && (!mem_w_valid || mem_w_data != prev_data)) hold_bad <= hold_bad + 1;
      prev_stall <= mem_w_valid && !mem_w_ready;
      prev_data  <= mem_w_data;
      if (mem_aw_valid && mem_aw_ready) begin
        aw_cnt <= aw_cnt + 1; aw_seen_addr <= mem_aw_addr; aw_seen_len <= mem_aw_len;
        wr_ptr = mem_aw_addr; aw_open = 1;
      end
      if (mem_w_valid && mem_w_ready) begin
        for (int k = 0; k < 8; k++) mem[((wr_ptr >> 2) + k) & 1023] <= mem_w_data[k*32 +: 32];
        wr_ptr = wr_ptr + 32;
        w_beats <= w_beats + 1;
        if (burst_idx == 0) first_w <= cyc;
        last_w <= cyc;
        if (mem_w_last != (burst_idx == 7)) wlast_bad <= wlast_bad + 1;
        if (mem_w_last) begin
          last_cnt <= last_cnt + 1; burst_idx <= 0; aw_open = 0; mem_b_valid <= 1;
        end else burst_idx <= burst_idx + 1;
      end
      if (mem_b_valid && mem_b_ready) mem_b_valid <= 0;
      mem_w_ready <= aw_open && (!wstall_en || (cyc % 3) != 0);
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); csr_wr = 1; csr_addr = a; csr_wdata = d;
    @(negedge clk); csr_wr = 0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); csr_rd = 1; csr_addr = a;
    @(negedge clk); csr_rd = 0; d = csr_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check(!mem_ar_valid && !mem_aw_valid && !mem_w_valid, "R1 valids low", {mem_ar_valid, mem_aw_valid, mem_w_valid}, 0);
    check(eng_idle && !eng_done, "R1 idle/done pins", {eng_idle, eng_done}, 2);
    reg_read(8'h00, v);
    check(v == 32'h4, "R1 ctrl reset value", v, 32'h4);
  endtask

  task automatic t_addr_regs();
    logic [31:0] v;
    reg_write(8'h10, 32'h1234_567F); reg_read(8'h10, v);
    check(v == 32'h1234_5640, "R6 src low bits dropped", v, 32'h1234_5640);
    reg_write(8'h1C, 32'hFFFF_FFFF); reg_read(8'h1C, v);
    check(v == 32'hFFFF_FFC0, "R6 dst low bits dropped", v, 32'hFFFF_FFC0);
  endtask

  task automatic run(input logic [31:0] src, input logic [31:0] dst, input int mode,
                     input bit rs, input bit ws, input string name);
    logic [31:0] v, inv [64];
    int ar0, aw0, w0, l0, wl0, h0, mism, polls;
    bit seen;
    for (int i = 0; i < 64; i++) begin
      if (mode == 0) inv[i] = 32'(i * 3) - 32'd50;
      else if (i < 32) inv[i] = 32'h7FFF_FFF0 + 32'(i);
      else inv[i] = 32'hFFFF_FFC0 + 32'(i);
      mem[((src >> 2) + 32'(i)) & 1023] = inv[i];
      mem[((dst >> 2) + 32'(i)) & 1023] = 32'hDEAD_BEEF;
    end
    rstall_en = rs; wstall_en = ws;
    ar0 = ar_cnt; aw0 = aw_cnt; w0 = w_beats; l0 = last_cnt; wl0 = wlast_bad; h0 = hold_bad;
    reg_write(8'h10, src); reg_write(8'h1C, dst); reg_write(8'h00, 32'h1);
    reg_read(8'h00, v);
    check(v[0] == 0, {name, " R2 start self-cleared"}, v, 0);
    check(v[2] == 0, {name, " R9 idle low while running"}, v, 0);
    seen = 0; polls = 0;
    while (!seen && polls < 400) begin reg_read(8'h00, v); seen = v[1]; polls++; end
    check(seen, {name, " R9 done observed"}, v, 32'h6);
    check(v[2] == 1, {name, " R9 idle after done"}, v, 32'h6);
    reg_read(8'h00, v);
    check(v[1] == 0, {name, " R9 done cleared by read"}, v, 32'h4);
    check(ar_cnt - ar0 == 1 && ar_seen_addr == src && ar_seen_len == 7, {name, " R3 read burst"},
          {ar_seen_addr, 24'(ar_cnt - ar0), ar_seen_len}, {src, 24'd1, 8'd7});
    check(aw_cnt - aw0 == 1 && aw_seen_addr == dst && aw_seen_len == 7, {name, " R3 write burst"},
          {aw_seen_addr, 24'(aw_cnt - aw0), aw_seen_len}, {dst, 24'd1, 8'd7});
    check(w_beats - w0 == 8, {name, " R3 write beat count"}, w_beats - w0, 8);
    check(last_cnt - l0 == 1 && wlast_bad == wl0, {name, " R10 last on beat 8"}, wlast_bad - wl0, 0);
    check(hold_bad == h0, {name, " R7 stalled beat held"}, hold_bad - h0, 0);
    mism = 0;
    for (int i = 0; i < 64; i++) begin
      v = mem[((dst >> 2) + 32'(i)) & 1023];
      if (v != inv[i] + 32'd100) begin
        if (mism == 0) check(0, {name, " R4 element value"}, v, inv[i] + 32'd100);
        mism++;
      end
    end
    check(mism == 0, {name, " R4 R7 all 64 elements"}, mism, 0);
    if (mode == 1) begin
      v = mem[((dst >> 2) + 15) & 1023];
      check(v == 32'h8000_0063, {name, " R5 signed wrap"}, v, 32'h8000_0063);
      v = mem[((dst >> 2) + 63) & 1023];
      check(v == 32'h0000_0063, {name, " R5 unsigned wrap"}, v, 32'h63);
    end
    if (!rs && !ws) check(last_w - first_w == 7, {name, " R8 one beat per cycle"}, last_w - first_w, 7);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_addr_regs();
    run(32'h0000_0400, 32'h0000_0800, 0, 0, 0, "plain");
    run(32'h0000_0C40, 32'h0000_0040, 1, 0, 1, "wrap_wstall");
    run(32'h0000_0800, 32'h0000_0400, 0, 1, 1, "both_stall");
    run(32'h0000_0100, 32'h0000_0300, 1, 1, 0, "wrap_rstall");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule